// File: doc/BRIEF.md
# Transmit Status and Interrupt Controller

This block sits between a processor register port and a frame transmitter. The transmitter pulses `attempt_done` each time a transmit or retransmit attempt ends. With that pulse it gives four outcome flags: underflow, collision, sixteen attempts reached, and success. The block captures these flags into a status register. A freshness flag in the same register tells software whether it has already read the current status. A command register holds one interrupt enable per outcome. When a captured outcome has its enable set, `irq` rises. Reading the status register lowers it again.

Bits 6 and 5 of the command register select an extended register bank. When both are zero, the port behaves as the plain legacy map: only the status/command location exists, and every other address reads 0. When either bit is set, accesses to any non-status address are passed out as strobes to an external bank. The returned data is muxed back onto the read bus.

Top module: `tx_stat_irq_ctrl`

## Requirements
- R1: One cycle after an `attempt_done` pulse, status bits [3:0] hold the flags given with it: bit 0 underflow, bit 1 collision, bit 2 sixteen attempts, bit 3 success. They are read at address 0.
- R2: Status bit 7 (freshness flag) reads 1 after a status read and 0 after a status load.
- R3: After reset, the status reads 0x80, all command bits are 0 and `irq` is low.
- R4: Status bits 6 to 4 always read 0.
- R5: Status bit 3 is 1 only when the load carried the success flag.
- R6: `irq` rises the cycle after a load in which at least one flag has its enable set. It falls the cycle after a status read. Otherwise it holds.
- R7: Command bits [3:0] each enable exactly the condition of the matching status bit. A flag whose enable is 0 never raises `irq`.
- R8: While command bits 6:5 are 00, no extended strobe is produced and reads at addresses 1 to 7 return 0.
- R9: While command bits 6:5 are nonzero, an access at addresses 1 to 7 produces `ext_rd`/`ext_wr` in the same cycle. It presents `ext_bank` equal to those bits, and a read returns `ext_rdata`.
- R10: When a status read and a load fall in the same cycle, the load wins. The freshness flag ends at 0 and `irq` follows the load's enabled flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register port select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when no read) |
| attempt_done | input | 1 | End-of-attempt pulse |
| fl_underflow | input | 1 | Attempt ended in underflow |
| fl_collision | input | 1 | Attempt saw a collision |
| fl_max_tries | input | 1 | Sixteenth attempt reached |
| fl_success | input | 1 | Attempt succeeded |
| irq | output | 1 | Interrupt request |
| ext_rd | output | 1 | Extended bank read strobe |
| ext_wr | output | 1 | Extended bank write strobe |
| ext_bank | output | 2 | Selected extended bank |
| ext_addr | output | 3 | Address within the bank |
| ext_rdata | input | 8 | Read data from the extended bank |

## Verification
On every cycle, the assertions check the following:
- a load clears the freshness flag, and a lone status read sets it;
- a lone read drops `irq`;
- `irq` never rises without an enabled flag in the previous load;
- reserved bits stay 0;
- the success bit never appears without the success flag;
- no extended strobe occurs in legacy mode.

Only the bench's scenarios can show the following:
- the exact values captured for varied flag patterns;
- that each enable bit gates only its own condition;
- the read-and-load collision outcome;
- the correct hand-off of data from the extended bank.

// File: rtl/tx_stat_irq_ctrl.sv
module tx_stat_irq_ctrl #(
  parameter int AW      = 3,
  parameter int ST_ADDR = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          attempt_done,
  input  logic          fl_underflow,
  input  logic          fl_collision,
  input  logic          fl_max_tries,
  input  logic          fl_success,
  output logic          irq,
  output logic          ext_rd,
  output logic          ext_wr,
  output logic [1:0]    ext_bank,
  output logic [AW-1:0] ext_addr,
  input  logic [7:0]    ext_rdata
);
  localparam int NCOND = 4;

  logic [NCOND-1:0] cond_q;
  logic             fresh_q;
  logic [7:0]       cmd_q;
  logic             irq_q;

  logic [NCOND-1:0] flags;
  logic             st_sel, st_rd, cmd_wr, ext_hit, hit;

  assign flags   = {fl_success, fl_max_tries, fl_collision, fl_underflow};
  assign st_sel  = bus_cs && (bus_addr == AW'(ST_ADDR));
  assign st_rd   = st_sel && bus_rd;
  assign cmd_wr  = st_sel && bus_wr;
  assign ext_hit = bus_cs && (bus_addr != AW'(ST_ADDR)) && (cmd_q[6:5] != 2'b00);
  assign ext_rd  = ext_hit && bus_rd;
  assign ext_wr  = ext_hit && bus_wr;
  assign ext_bank = cmd_q[6:5];
  assign ext_addr = bus_addr;
  assign hit     = |(flags & cmd_q[NCOND-1:0]);
  assign irq     = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (st_rd)       bus_rdata = {fresh_q, 3'b000, cond_q};
    else if (ext_rd) bus_rdata = ext_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= '0;
      fresh_q <= 1'b1;
      cmd_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= bus_wdata;
      if (attempt_done) begin
        cond_q  <= flags;
        fresh_q <= 1'b0;
      end else if (st_rd) begin
        fresh_q <= 1'b1;
      end
      if (attempt_done && hit) irq_q <= 1'b1;
      else if (st_rd)          irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_stat_irq_chk.sv
module tx_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       st_rd,
  input logic       attempt_done,
  input logic       hit,
  input logic       fresh_q,
  input logic [3:0] cond_q,
  input logic       fl_success,
  input logic       irq,
  input logic [7:0] bus_rdata,
  input logic [1:0] ext_bank,
  input logic       ext_rd,
  input logic       ext_wr
);
  p_load_clears_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_done |=> !fresh_q);
  p_read_sets_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !attempt_done) |=> fresh_q);
  p_read_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !attempt_done) |=> !irq);
  p_irq_needs_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(attempt_done) && $past(hit)));
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |-> (bus_rdata[6:4] == 3'b000));
  p_success_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_done && !fl_success) |=> !cond_q[3]);
  p_legacy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_bank == 2'b00) |-> (!ext_rd && !ext_wr));
  p_collide_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && attempt_done) |=> (!fresh_q && (irq == $past(hit))));
endmodule

bind tx_stat_irq_ctrl tx_stat_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st_rd(st_rd), .attempt_done(attempt_done),
  .hit(hit), .fresh_q(fresh_q), .cond_q(cond_q), .fl_success(fl_success),
  .irq(irq), .bus_rdata(bus_rdata), .ext_bank(ext_bank),
  .ext_rd(ext_rd), .ext_wr(ext_wr)
);

// File: tb/tx_stat_irq_ctrl_tb.sv
`timescale 1ns/1ps
module tx_stat_irq_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic cs = 0, rd = 0, wr = 0, done = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, xdata = 8'hA5;
  logic [3:0] fl = 0;
  logic irq, xrd, xwr;
  logic [1:0] xbank;
  logic [2:0] xaddr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tx_stat_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .attempt_done(done), .fl_underflow(fl[0]), .fl_collision(fl[1]),
    .fl_max_tries(fl[2]), .fl_success(fl[3]), .irq(irq),
    .ext_rd(xrd), .ext_wr(xwr), .ext_bank(xbank), .ext_addr(xaddr),
    .ext_rdata(xdata)
  );

  // behavioural reference state
  int m_stat, m_cmd;
  bit m_irq;
  always @(posedge clk) begin
    bit srd;
    srd = cs && rd && addr == 0;
    if (!rst_n) begin
      m_stat = 128; m_cmd = 0; m_irq = 0;
    end else begin
      if (cs && wr && addr == 0) m_cmd = wdata;
      if (done) begin
        m_stat = fl;
        if ((fl & m_cmd[3:0]) != 0) m_irq = 1;
        else if (srd) m_irq = 0;
      end else if (srd) begin
        m_stat = m_stat | 128;
        m_irq = 0;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // compared on every clock, before the bench changes inputs
  always @(negedge clk) if (rst_n) begin
    bit ext;
    int er;
    ext = cs && addr != 0 && ((m_cmd >> 5) & 3) != 0;
    er = (cs && rd && addr == 0) ? m_stat : (ext && rd) ? xdata : 0;
    chk("R6 irq", irq, m_irq);
    chk("R1 rdata", rdata, er);
    chk("R9 ext_rd", xrd, ext && rd);
    chk("R9 ext_wr", xwr, ext && wr);
  end

  task automatic drive(bit c, bit r, bit w, int a, int d, bit dn, int f);
    @(negedge clk); #2;
    cs = c; rd = r; wr = w; addr = a[2:0]; wdata = d[7:0]; done = dn; fl = f[3:0];
  endtask
  task automatic idle(); drive(0,0,0,0,0,0,0); endtask
  task automatic wcmd(int v); drive(1,0,1,0,v,0,0); idle(); endtask
  task automatic load(int f); drive(0,0,0,0,0,1,f); idle(); endtask
  task automatic rstat(string tag, int exp);
    drive(1,1,0,0,0,0,0); #1; chk(tag, rdata, exp); idle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    #1 chk("R3 irq after reset", irq, 0);
    rstat("R3 status after reset", 8'h80);
    rstat("R2 fresh after read", 8'h80);
    // no enables: loads never raise irq (R7)
    load(4'hF); #1 chk("R7 disabled flags no irq", irq, 0);
    rstat("R1 all flags R4 reserved zero", 8'h0F);
    load(4'h2); rstat("R5 no success bit", 8'h02);
    // enable collision only
    wcmd(8'h02);
    load(4'h1); #1 chk("R7 underflow masked", irq, 0);
    load(4'h2); #1 chk("R6 collision raises irq", irq, 1);
    idle(); #1 chk("R6 irq holds", irq, 1);
    rstat("R2 fresh cleared by load", 8'h02);
    #1 chk("R6 irq cleared by read", irq, 0);
    wcmd(8'h08);
    load(4'h8); #1 chk("R5 success irq", irq, 1);
    rstat("R5 success bit", 8'h08);
    // R10 read and load together
    drive(1,1,0,0,0,1,4'h8); idle();
    #1 chk("R10 irq follows load", irq, 1);
    rstat("R10 load wins fresh 0", 8'h08);
    drive(1,1,0,0,0,1,4'h1); idle();
    #1 chk("R10 unenabled load clears irq", irq, 0);
    // R8 legacy reads elsewhere
    for (int a = 1; a < 8; a++) begin
      drive(1,1,0,a,0,0,0); #1 chk("R8 legacy read zero", rdata, 0);
      chk("R8 no ext strobe", xrd, 0);
    end
    idle();
    // R9 extended bank
    wcmd(8'hC0);
    drive(1,1,0,3,0,0,0); #1;
    chk("R9 ext read data", rdata, 8'hA5);
    chk("R9 ext bank", xbank, 2);
    chk("R9 ext addr", xaddr, 3);
    drive(1,0,1,5,8'h3C,0,0); #1 chk("R9 ext write", xwr, 1);
    idle();
    // legacy again
    wcmd(8'h80);
    drive(1,0,1,4,0,0,0); #1 chk("R8 bit7 alone legacy", xwr, 0);
    idle();
    for (int i = 0; i < 200; i++) begin
      drive($urandom_range(0,1), $urandom_range(0,1), 0, $urandom_range(0,1) * $urandom_range(0,7),
            0, $urandom_range(0,1), $urandom_range(0,15));
    end
    wcmd(8'h0F);
    for (int i = 0; i < 200; i++) begin
      drive(1, $urandom_range(0,1), 0, 0, 0, $urandom_range(0,1), $urandom_range(0,15));
    end
    idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule